// File: doc/BRIEF.md
# Reset-Cause Status Register

This block keeps a small status word that tells start-up firmware which event caused the most recent reset. One-cycle cause pulses arrive from the reset generator: power-on, supply droop (brown-out), external reset pin, software request, watchdog timeout and configuration-check failure. A two-bit power-state input says whether the core was running, idling or sleeping when the event arrived. Each kind of event updates its own set of flags, so after any reset the word shows the newest cause together with whatever history that cause does not erase.

Software reaches the word over a simple register bus with four word-sized windows. The first window reads and writes the word directly. The other three clear, set or invert only the bits written as one. A regulator-standby control bit sits in the same word and is left alone by every event except a power-on, which keeps it too. Writing a flag from software only changes the stored status. The block has no reset output, so such a write cannot start a reset.

Top module: `rcause_status`

## Requirements
- R1: After the asynchronous reset `rst_n`, a read of the direct window (byte offset 0x0) returns 0x003: power-on flag (bit 0) and brown-out flag (bit 1) set, every other bit zero.
- R2: Implemented bits are power-on 0, brown-out 1, idle 2, sleep 3, watchdog 4, software 6, external pin 7, regulator standby 8, configuration mismatch 9. Bit 5 and bits 10 and up always read zero and ignore writes through every window.
- R3: A write to the direct window (offset 0x0) replaces all implemented bits with the written data.
- R4: A write to offset 0x4 clears, to 0x8 sets and to 0xC inverts exactly the implemented bits written as 1. Reads from these three offsets return zero. The window is picked by address bits [3:2]. Bits [1:0] are ignored.
- R5: A power-on pulse sets the power-on and brown-out flags, clears bits 2, 3, 4, 6, 7 and 9, and keeps regulator standby.
- R6: A brown-out pulse sets the brown-out flag and clears the idle, sleep, watchdog, software, external and mismatch flags. It leaves the power-on flag and regulator standby unchanged. Cause pulses that arrive in the same cycle are still recorded.
- R7: An external, software, watchdog or mismatch pulse sets only its own flag. All other bits stay unchanged.
- R8: A watchdog or external pulse with `pwr_mode` = 2'b10 (sleep) also sets the sleep flag. With `pwr_mode` = 2'b01 (idle) it also sets the idle flag. Values 2'b00 and 2'b11 mean running and add nothing. Software and mismatch pulses never set sleep or idle.
- R9: When a hardware cause sets a flag in the same cycle that a software write would clear it, the flag ends up set.
- R10: A power-on pulse overrides any bus write in the same cycle. The result is 0x003 plus the regulator-standby value held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the power-on pattern |
| bus_sel | input | 1 | Bus access strobe for this block |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] pick the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational; zero unless the direct window is read |
| ev_por | input | 1 | Power-on cause pulse |
| ev_bor | input | 1 | Brown-out cause pulse |
| ev_ext | input | 1 | External reset pin cause pulse |
| ev_swr | input | 1 | Software reset cause pulse |
| ev_wdt | input | 1 | Watchdog timeout cause pulse |
| ev_cfg | input | 1 | Configuration mismatch cause pulse |
| pwr_mode | input | 2 | Power state at the event: 00 run, 01 idle, 10 sleep, 11 run |

## Verification
The bench builds the block with its default values, DATA_W = 32 and ADDR_W = 4. This makes all four windows addressable and leaves twenty-two unimplemented upper bits plus bit 5 to test the write-ignore rule. With that width, every bus address hits one of the windows, so decoding is reduced to the window choice. Cause pulses are driven alone, combined with each other, combined with bus writes and under every power-state code. This exercises the priority between the brown-out clear, the individual sets, a software clear in the same cycle and the power-on override.

// File: rtl/rcause_pkg.sv
package rcause_pkg;

    localparam int REG_W = 10;

    localparam logic [REG_W-1:0] IMPL_MASK = 10'h3DF;

    typedef struct packed {
        logic cfgmis;     // bit 9
        logic vreg_stby;  // bit 8
        logic ext;        // bit 7
        logic swr;        // bit 6
        logic rsvd5;      // bit 5, always zero
        logic wdt;        // bit 4
        logic sleep;      // bit 3
        logic idle;       // bit 2
        logic bor;        // bit 1
        logic por;        // bit 0
    } cause_reg_t;

    typedef enum logic [1:0] {
        WIN_DIRECT = 2'd0,
        WIN_CLEAR  = 2'd1,
        WIN_SET    = 2'd2,
        WIN_INVERT = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        PW_RUN   = 2'b00,
        PW_IDLE  = 2'b01,
        PW_SLEEP = 2'b10,
        PW_RSVD  = 2'b11
    } pwr_e;

    typedef struct packed {
        logic cfg;
        logic wdt;
        logic swr;
        logic ext;
        logic bor;
        logic por;
    } cause_ev_t;

endpackage

// File: rtl/rcause_bus_dec.sv
module rcause_bus_dec
    import rcause_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic              rd_direct,
    output win_e              win
);

    logic hit;

    generate
        if (ADDR_W > 4) begin : g_upper
            assign hit = sel && (addr[ADDR_W-1:4] == '0);
        end else begin : g_flat
            assign hit = sel;
        end
    endgenerate

    always_comb begin
        win       = win_e'(addr[3:2]);
        wr_en     = hit && wr;
        rd_direct = hit && !wr && (win == WIN_DIRECT);
    end

endmodule

// File: rtl/rcause_sw_upd.sv
module rcause_sw_upd
    import rcause_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  logic             wr_en,
    input  win_e             win,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] nxt
);

    logic [REG_W-1:0] wm;

    always_comb begin
        wm  = wdata & IMPL_MASK;
        nxt = cur;
        if (wr_en) begin
            unique case (win)
                WIN_DIRECT: nxt = (cur & ~IMPL_MASK) | wm;
                WIN_CLEAR:  nxt = cur & ~wm;
                WIN_SET:    nxt = cur | wm;
                WIN_INVERT: nxt = cur ^ wm;
                default:    nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/rcause_hw_upd.sv
module rcause_hw_upd
    import rcause_pkg::*;
(
    input  cause_reg_t held,
    input  cause_reg_t sw_in,
    input  cause_ev_t  ev,
    input  pwr_e       pwr,
    output cause_reg_t nxt
);

    logic in_sleep;
    logic in_idle;
    logic wake_src;

    always_comb begin
        in_sleep = (pwr == PW_SLEEP);
        in_idle  = (pwr == PW_IDLE);
        wake_src = ev.wdt || ev.ext;

        nxt = sw_in;

        if (ev.bor) begin
            nxt.ext    = 1'b0;
            nxt.swr    = 1'b0;
            nxt.wdt    = 1'b0;
            nxt.sleep  = 1'b0;
            nxt.idle   = 1'b0;
            nxt.cfgmis = 1'b0;
            nxt.bor    = 1'b1;
        end

        nxt.ext    = nxt.ext    | ev.ext;
        nxt.swr    = nxt.swr    | ev.swr;
        nxt.wdt    = nxt.wdt    | ev.wdt;
        nxt.cfgmis = nxt.cfgmis | ev.cfg;
        nxt.sleep  = nxt.sleep  | (wake_src && in_sleep);
        nxt.idle   = nxt.idle   | (wake_src && in_idle);

        if (ev.por) begin
            nxt           = '0;
            nxt.por       = 1'b1;
            nxt.bor       = 1'b1;
            nxt.vreg_stby = held.vreg_stby;
        end

        nxt.rsvd5 = 1'b0;
    end

endmodule

// File: rtl/rcause_status.sv
module rcause_status
    import rcause_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_por,
    input  logic              ev_bor,
    input  logic              ev_ext,
    input  logic              ev_swr,
    input  logic              ev_wdt,
    input  logic              ev_cfg,
    input  logic [1:0]        pwr_mode
);

    localparam int PAD_W = DATA_W - REG_W;
    localparam cause_reg_t POR_VALUE = cause_reg_t'(10'h003);

    typedef struct packed {
        cause_reg_t flags;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic             wr_en;
    logic             rd_direct;
    win_e             win;
    logic [REG_W-1:0] sw_nxt;
    cause_reg_t       hw_nxt;
    cause_ev_t        ev;

    assign ev = '{cfg: ev_cfg, wdt: ev_wdt, swr: ev_swr,
                  ext: ev_ext, bor: ev_bor, por: ev_por};

    rcause_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
        .sel       (bus_sel),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wr_en     (wr_en),
        .rd_direct (rd_direct),
        .win       (win)
    );

    rcause_sw_upd u_sw (
        .cur   (state_q.flags),
        .wr_en (wr_en),
        .win   (win),
        .wdata (bus_wdata[REG_W-1:0]),
        .nxt   (sw_nxt)
    );

    rcause_hw_upd u_hw (
        .held  (state_q.flags),
        .sw_in (cause_reg_t'(sw_nxt)),
        .ev    (ev),
        .pwr   (pwr_e'(pwr_mode)),
        .nxt   (hw_nxt)
    );

    always_comb begin
        state_d       = state_q;
        state_d.flags = hw_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.flags <= POR_VALUE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_direct) begin
            bus_rdata = {{PAD_W{1'b0}}, state_q.flags};
        end
    end

    // Unimplemented read bits stay zero (R2)
    p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~{{PAD_W{1'b0}}, IMPL_MASK}) == '0);

    // Alias windows read as zero (R4)
    p_alias_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[3:2] != 2'd0) |-> bus_rdata == '0);

    // Power-on pattern (R5)
    p_por_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_por |=> (state_q.flags.por && state_q.flags.bor && !state_q.flags.ext
                    && !state_q.flags.swr && !state_q.flags.wdt && !state_q.flags.sleep
                    && !state_q.flags.idle && !state_q.flags.cfgmis
                    && state_q.flags.vreg_stby == $past(state_q.flags.vreg_stby)));

    // Brown-out alone keeps the power-on flag and clears history (R6)
    p_bor_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bor && !ev_por && !ev_ext && !ev_swr && !ev_wdt && !ev_cfg && !wr_en)
        |=> (state_q.flags.bor && state_q.flags.por == $past(state_q.flags.por)
             && !state_q.flags.ext && !state_q.flags.swr && !state_q.flags.wdt
             && !state_q.flags.sleep && !state_q.flags.idle && !state_q.flags.cfgmis));

    // Individual cause sets its flag (R7)
    p_own_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_por && (ev_swr || ev_cfg))
        |=> ((!$past(ev_swr) || state_q.flags.swr) && (!$past(ev_cfg) || state_q.flags.cfgmis)));

    // Watchdog in sleep records sleep (R8)
    p_wdt_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt && pwr_mode == 2'b10 && !ev_por) |=> (state_q.flags.sleep && state_q.flags.wdt));

    // Hardware set wins over a software write (R9)
    p_hw_over_sw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ext && !ev_por && wr_en) |=> state_q.flags.ext);

    // Power-on overrides a software write (R10)
    p_por_over_sw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_por && wr_en) |=> ((state_q.flags & ~10'h100) == 10'h003));

endmodule

// File: tb/rcause_status_test.sv
module rcause_status_test;

    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          ev_por = 1'b0, ev_bor = 1'b0, ev_ext = 1'b0;
    logic          ev_swr = 1'b0, ev_wdt = 1'b0, ev_cfg = 1'b0;
    logic [1:0]    pwr_mode = 2'b00;

    always #10 clk = ~clk;

    rcause_status #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_por(ev_por), .ev_bor(ev_bor), .ev_ext(ev_ext), .ev_swr(ev_swr),
        .ev_wdt(ev_wdt), .ev_cfg(ev_cfg), .pwr_mode(pwr_mode)
    );

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            n_checks = 0;
    int            n_fail = 0;
    logic [DW-1:0] model = 32'h0000_0003;
    bit            done = 1'b0;

    // event vector order: {cfg, wdt, swr, ext, bor, por}
    function automatic logic [DW-1:0] predict(input logic [DW-1:0] cur, input logic wr,
                                              input logic [3:0] addr, input logic [DW-1:0] d,
                                              input logic [5:0] ev, input logic [1:0] pw);
        logic [DW-1:0] r;
        logic [DW-1:0] w;
        r = cur;
        w = d & 32'h0000_03DF;
        if (wr) begin
            case (addr[3:2])
                2'd0: r = (cur & ~32'h0000_03DF) | w;
                2'd1: r = cur & ~w;
                2'd2: r = cur | w;
                default: r = cur ^ w;
            endcase
        end
        if (ev[1]) r = (r & ~32'h0000_02DC) | 32'h2;
        if (ev[2]) r = r | 32'h80;
        if (ev[3]) r = r | 32'h40;
        if (ev[4]) r = r | 32'h10;
        if (ev[5]) r = r | 32'h200;
        if ((ev[4] || ev[2]) && pw == 2'b10) r = r | 32'h8;
        if ((ev[4] || ev[2]) && pw == 2'b01) r = r | 32'h4;
        if (ev[0]) r = (cur & 32'h100) | 32'h3;
        return r;
    endfunction

    task automatic step(input logic wr, input logic [3:0] addr, input logic [DW-1:0] d,
                        input logic [5:0] ev, input logic [1:0] pw);
        @(negedge clk);
        bus_sel   = wr;
        bus_wr    = wr;
        bus_addr  = addr;
        bus_wdata = d;
        {ev_cfg, ev_wdt, ev_swr, ev_ext, ev_bor, ev_por} = ev;
        pwr_mode  = pw;
        model     = predict(model, wr, addr, d, ev, pw);
    endtask

    task automatic bus_write(input logic [3:0] addr, input logic [DW-1:0] d);
        step(1'b1, addr, d, 6'b0, 2'b00);
    endtask

    task automatic cause(input logic [5:0] ev, input logic [1:0] pw);
        step(1'b0, 4'h0, '0, ev, pw);
    endtask

    task automatic bus_read(input logic [3:0] addr, input string tag);
        exp_t e;
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = 1'b0;
        bus_addr  = addr;
        {ev_cfg, ev_wdt, ev_swr, ev_ext, ev_bor, ev_por} = 6'b0;
        e.exp = (addr[3:2] == 2'd0) ? model : '0;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares a quarter period after each read is driven
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (bus_sel && !bus_wr) begin
                exp_t e;
                n_checks++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
                end else begin
                    e = sb.pop_front();
                    if (bus_rdata !== e.exp) begin
                        n_fail++;
                        $display("FAIL %s: actual %h expected %h", e.tag, bus_rdata, e.exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_read(4'h0, "R1 reset value");
        bus_read(4'h4, "R4 clear window reads zero");
        bus_read(4'h8, "R4 set window reads zero");
        bus_read(4'hC, "R4 invert window reads zero");

        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, "R2 all-ones write keeps unimplemented zero");
        bus_write(4'h0, 32'h0000_0140);
        bus_read(4'h1, "R3 direct write replaces, low addr bits ignored");
        bus_write(4'h8, 32'h0000_0291);
        bus_read(4'h0, "R4 set window");
        bus_write(4'h4, 32'hFFFF_FC20);
        bus_read(4'h0, "R2 clear of unimplemented bits ignored");
        bus_write(4'hC, 32'h0000_030F);
        bus_read(4'h0, "R4 invert window");
        bus_write(4'h8, 32'hFFFF_FC20);
        bus_read(4'h0, "R2 set of unimplemented bits ignored");

        bus_write(4'h0, 32'h0000_03DC);
        cause(6'b000001, 2'b00);
        bus_read(4'h0, "R5 power-on keeps standby, clears history");

        bus_write(4'h0, 32'h0000_03DD);
        cause(6'b000010, 2'b00);
        bus_read(4'h0, "R6 brown-out keeps power-on flag");
        bus_write(4'h0, 32'h0000_0100);
        cause(6'b000010, 2'b00);
        bus_read(4'h0, "R6 brown-out with power-on clear");
        bus_write(4'h0, 32'h0000_0050);
        cause(6'b000110, 2'b10);
        bus_read(4'h0, "R6 brown-out with external pulse");

        bus_write(4'h4, 32'h0000_03FF);
        cause(6'b000100, 2'b00);
        bus_read(4'h0, "R7 external only");
        cause(6'b001000, 2'b00);
        bus_read(4'h0, "R7 software only");
        cause(6'b100000, 2'b00);
        bus_read(4'h0, "R7 mismatch only");
        cause(6'b010000, 2'b00);
        bus_read(4'h0, "R7 watchdog only");

        bus_write(4'h4, 32'h0000_03FF);
        cause(6'b010000, 2'b10);
        bus_read(4'h0, "R8 watchdog in sleep");
        bus_write(4'h4, 32'h0000_03FF);
        cause(6'b000100, 2'b01);
        bus_read(4'h0, "R8 external in idle");
        bus_write(4'h4, 32'h0000_03FF);
        cause(6'b010000, 2'b11);
        bus_read(4'h0, "R8 code 11 acts as run");
        bus_write(4'h4, 32'h0000_03FF);
        cause(6'b101000, 2'b10);
        bus_read(4'h0, "R8 software and mismatch never mark sleep");

        bus_write(4'h0, 32'h0000_0000);
        step(1'b1, 4'h4, 32'h0000_0080, 6'b000100, 2'b00);
        bus_read(4'h0, "R9 external beats clear window");
        step(1'b1, 4'h0, 32'h0000_0000, 6'b010000, 2'b00);
        bus_read(4'h0, "R9 watchdog beats direct write");

        bus_write(4'h0, 32'h0000_0100);
        step(1'b1, 4'h8, 32'h0000_02C0, 6'b000001, 2'b00);
        bus_read(4'h0, "R10 power-on beats set window");
        step(1'b1, 4'hC, 32'h0000_0100, 6'b000001, 2'b00);
        bus_read(4'h0, "R10 power-on beats standby invert");

        @(negedge clk);
        bus_sel = 1'b0;
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule